// File: doc/BRIEF.md
# Interrupt Destination Mask Resolver

This block turns one interrupt message into the set of target agents that must receive it. A message carries a 32-bit destination, a physical/logical destination-mode flag, a two-bit shorthand and the index of the agent that sent it. Every agent supplies, through configuration inputs, whether it is present, whether it runs in extended (32-bit ID) mode, its physical ID, its logical ID and, for legacy agents, whether its logical ID uses the flat or the cluster model. The block matches all agents in parallel and produces one mask bit per agent.

The mask is resolved combinationally and captured in a register when a request is presented. The registered mask comes out with a single-cycle valid strobe. For lowest-priority delivery the block also reports the lowest-numbered agent in the mask, with a flag for an empty mask, so that a downstream stage can send the message to one agent only. Priority comparison between agents and the delivery of the vector itself are left to other logic.

Top module: `irq_dest_resolver`

## Requirements
- R1: After reset, out_valid is 0, out_mask is all zeros and out_pick_found is 0.
- R2: out_valid is 1 in exactly the cycle after a cycle with req_valid 1, and out_mask and the pick outputs keep their value while req_valid is 0.
- R3: req_shorthand selects the source of the mask: 0 uses the destination field, 1 selects only the agent at index req_sender, 2 selects every agent, 3 selects every agent except req_sender.
- R4: With req_logical 0, a legacy agent (cfg_ext bit 0) is selected when bits 7:0 of req_dest equal bits 7:0 of its physical ID, and every legacy agent is selected when req_dest equals 32'h0000_00FF.
- R5: With req_logical 0, an extended agent is selected when req_dest equals its full 32-bit physical ID, and req_dest 32'hFFFF_FFFF selects every agent.
- R6: With req_logical 1, an extended agent is selected when req_dest[31:16] equals bits 31:16 of its logical ID and req_dest[15:0] AND bits 15:0 of its logical ID is nonzero.
- R7: With req_logical 1, a legacy agent in the flat model (cfg_cluster bit 0) is selected when req_dest[7:0] AND bits 7:0 of its logical ID is nonzero.
- R8: With req_logical 1, a legacy agent in the cluster model (cfg_cluster bit 1) is selected when req_dest[7:4] is 4'hF or equals bits 7:4 of its logical ID, and req_dest[3:0] AND bits 3:0 of its logical ID is nonzero.
- R9: With req_logical 1 and req_dest 32'hFFFF_FFFF, every extended agent is selected and the legacy agents are still matched under R7 and R8.
- R10: An agent whose cfg_present bit is 0 never appears in out_mask, for any shorthand or destination.
- R11: out_pick_found is 1 exactly when out_mask is nonzero, and out_pick_idx then names the lowest-numbered set bit of out_mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A message is presented this cycle |
| req_dest | input | 32 | Destination field |
| req_logical | input | 1 | 0 physical, 1 logical destination mode |
| req_shorthand | input | 2 | 0 destination, 1 self, 2 all, 3 all but self |
| req_sender | input | IDX_W | Index of the sending agent |
| cfg_present | input | N_AGENTS | Per-agent present flag |
| cfg_ext | input | N_AGENTS | Per-agent extended-mode flag |
| cfg_cluster | input | N_AGENTS | Per-agent legacy logical model, 1 cluster, 0 flat |
| cfg_phys_id | input | N_AGENTS*32 | Physical IDs, agent i in bits 32*i+31:32*i |
| cfg_log_id | input | N_AGENTS*32 | Logical IDs, agent i in bits 32*i+31:32*i |
| out_valid | output | 1 | One-cycle strobe for a resolved mask |
| out_mask | output | N_AGENTS | Resolved delivery mask, bit i is agent i |
| out_pick_found | output | 1 | The mask has at least one bit set |
| out_pick_idx | output | IDX_W | Lowest-numbered agent in the mask |

## Verification
The bench builds the resolver with N_AGENTS set to 8, which lets every agent be configured by hand: two flat legacy agents, two cluster legacy agents, three extended agents and one absent agent that carries an all-ones logical ID and a legacy ID that collides with a live one. With that population a single destination can hit legacy and extended agents at once, so the separate broadcast rules of the two populations, the absent-agent exclusion and the self and all-but-self shorthands at both ends of the index range all come within reach, and the lowest-pick output is checked on every mask.

// File: rtl/irq_dest_pkg.sv
// Package: shared encodings for the interrupt destination mask resolver.
// Assumes a 32-bit destination field in every message.
package irq_dest_pkg;

    localparam int DEST_W = 32;

    // Destination shorthand encoding; values are fixed by the message format.
    typedef enum logic [1:0] {
        SH_DEST   = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } shorthand_e;

    localparam logic [DEST_W-1:0] DEST_ALL_ONES  = 32'hFFFF_FFFF;
    localparam logic [DEST_W-1:0] DEST_LEGACY_BC = 32'h0000_00FF;
    localparam logic [3:0]        CLUSTER_ANY    = 4'hF;

endpackage

// File: rtl/irq_agent_match.sv
// Module: irq_agent_match
// Decides whether one agent is addressed by the destination field of a
// message (shorthand 0). Purely combinational. Assumes the caller applies the
// presence filter and the shorthand; this module looks only at the
// destination, the destination mode and the agent's own configuration.
module irq_agent_match
    import irq_dest_pkg::*;
(
    input  logic [DEST_W-1:0] dest,
    input  logic              logical,
    input  logic              is_ext,
    input  logic              is_cluster,
    input  logic [DEST_W-1:0] phys_id,
    input  logic [DEST_W-1:0] log_id,
    output logic              hit
);

    logic phys_hit;
    logic ext_log_hit;
    logic flat_hit;
    logic clus_hit;
    logic log_hit;

    // Physical mode: full-width compare for extended, low byte for legacy,
    // plus both broadcast forms.
    always_comb begin
        if (dest == DEST_ALL_ONES) begin
            phys_hit = 1'b1;
        end else if (is_ext) begin
            phys_hit = (phys_id == dest);
        end else begin
            phys_hit = (phys_id[7:0] == dest[7:0]) || (dest == DEST_LEGACY_BC);
        end
    end

    // Extended logical: cluster field compare plus member mask overlap.
    always_comb begin
        ext_log_hit = ((dest[31:16] == log_id[31:16]) && ((dest[15:0] & log_id[15:0]) != 16'h0))
                      || (dest == DEST_ALL_ONES);
    end

    // Legacy logical: flat overlap, or cluster number with wildcard and member overlap.
    always_comb begin
        flat_hit = ((dest[7:0] & log_id[7:0]) != 8'h0);
        clus_hit = ((dest[7:4] == CLUSTER_ANY) || (dest[7:4] == log_id[7:4]))
                   && ((dest[3:0] & log_id[3:0]) != 4'h0);
    end

    // Logical mode: pick the rule that matches the agent's mode and model.
    always_comb begin
        if (is_ext) begin
            log_hit = ext_log_hit;
        end else if (is_cluster) begin
            log_hit = clus_hit;
        end else begin
            log_hit = flat_hit;
        end
    end

    // Final select on destination mode.
    always_comb begin
        hit = logical ? log_hit : phys_hit;
    end

endmodule

// File: rtl/irq_lowest_pick.sv
// Module: irq_lowest_pick
// Finds the lowest-numbered set bit of a mask. Purely combinational.
// Assumes N is at least 2; idx is zero when no bit is set.
module irq_lowest_pick #(
    parameter int N     = 32,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     mask,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    // Scan from the top so the last assignment is the lowest set bit.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_dest_resolver.sv
// Module: irq_dest_resolver
// Resolves an interrupt message into a per-agent delivery mask and the
// lowest-numbered selected agent. Matching runs in parallel for all agents;
// the result is registered with a one-cycle valid strobe. Assumes the
// configuration inputs are stable in the cycle a request is presented and
// that req_sender is below N_AGENTS.
module irq_dest_resolver
    import irq_dest_pkg::*;
#(
    parameter int N_AGENTS = 32,
    parameter int IDX_W    = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [DEST_W-1:0]          req_dest,
    input  logic                       req_logical,
    input  logic [1:0]                 req_shorthand,
    input  logic [IDX_W-1:0]           req_sender,
    input  logic [N_AGENTS-1:0]        cfg_present,
    input  logic [N_AGENTS-1:0]        cfg_ext,
    input  logic [N_AGENTS-1:0]        cfg_cluster,
    input  logic [N_AGENTS*DEST_W-1:0] cfg_phys_id,
    input  logic [N_AGENTS*DEST_W-1:0] cfg_log_id,
    output logic                       out_valid,
    output logic [N_AGENTS-1:0]        out_mask,
    output logic                       out_pick_found,
    output logic [IDX_W-1:0]           out_pick_idx
);

    localparam logic [N_AGENTS-1:0] ONE_N = N_AGENTS'(1);

    shorthand_e          sh;
    logic [N_AGENTS-1:0] dest_hit;
    logic [N_AGENTS-1:0] mask_c;
    logic                found_c;
    logic [IDX_W-1:0]    idx_c;

    assign sh = shorthand_e'(req_shorthand);

    for (genvar g = 0; g < N_AGENTS; g++) begin : g_agent
        // Destination-field match for agent g.
        irq_agent_match u_match (
            .dest       (req_dest),
            .logical    (req_logical),
            .is_ext     (cfg_ext[g]),
            .is_cluster (cfg_cluster[g]),
            .phys_id    (cfg_phys_id[g*DEST_W +: DEST_W]),
            .log_id     (cfg_log_id[g*DEST_W +: DEST_W]),
            .hit        (dest_hit[g])
        );

        // Shorthand select and presence filter for agent g.
        always_comb begin
            unique case (sh)
                SH_DEST:   mask_c[g] = dest_hit[g];
                SH_SELF:   mask_c[g] = (req_sender == IDX_W'(g));
                SH_ALL:    mask_c[g] = 1'b1;
                SH_OTHERS: mask_c[g] = (req_sender != IDX_W'(g));
                default:   mask_c[g] = 1'b0;
            endcase
            mask_c[g] = mask_c[g] & cfg_present[g];
        end
    end

    irq_lowest_pick #(.N(N_AGENTS), .IDX_W(IDX_W)) u_pick (
        .mask  (mask_c),
        .found (found_c),
        .idx   (idx_c)
    );

    // Output register: strobe every cycle, capture results only on a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid      <= 1'b0;
            out_mask       <= '0;
            out_pick_found <= 1'b0;
            out_pick_idx   <= '0;
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                out_mask       <= mask_c;
                out_pick_found <= found_c;
                out_pick_idx   <= idx_c;
            end
        end
    end

    AST_VALID_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(req_valid)); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(out_mask) && $stable(out_pick_idx)); // R2
    AST_ABSENT_EXCLUDED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (out_mask & ~$past(cfg_present)) == '0); // R10
    AST_SELF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_shorthand == 2'd1 |=> $countones(out_mask) <= 1); // R3
    AST_OTHERS_NOT_SENDER: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_shorthand == 2'd3 |=> !out_mask[$past(req_sender)]); // R3
    AST_PICK_FOUND: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_pick_found == (out_mask != '0)); // R11
    AST_PICK_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_pick_found |-> out_mask[out_pick_idx]); // R11
    AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_pick_found |-> (out_mask & ((ONE_N << out_pick_idx) - ONE_N)) == '0); // R11

endmodule

// File: tb/irq_dest_resolver_bench.sv
// Bench for irq_dest_resolver with eight hand-configured agents.
module irq_dest_resolver_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int IW = 3;
    localparam int NV = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [31:0]   req_dest = '0;
    logic          req_logical = 1'b0;
    logic [1:0]    req_shorthand = '0;
    logic [IW-1:0] req_sender = '0;
    logic [N-1:0]  cfg_present;
    logic [N-1:0]  cfg_ext;
    logic [N-1:0]  cfg_cluster;
    logic [N*32-1:0] cfg_phys_id;
    logic [N*32-1:0] cfg_log_id;
    logic          out_valid;
    logic [N-1:0]  out_mask;
    logic          out_pick_found;
    logic [IW-1:0] out_pick_idx;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_dest_resolver #(.N_AGENTS(N)) u_irq_dest_resolver (
        .clk, .rst_n, .req_valid, .req_dest, .req_logical, .req_shorthand,
        .req_sender, .cfg_present, .cfg_ext, .cfg_cluster, .cfg_phys_id,
        .cfg_log_id, .out_valid, .out_mask, .out_pick_found, .out_pick_idx
    );

    // Vector: {dest, logical, shorthand, sender, expected mask}
    localparam logic [45:0] VEC [NV] = '{
        {32'h0000_0003, 1'b0, 2'd0, 3'd0, 8'h01}, // R4 legacy low byte
        {32'h0000_0005, 1'b0, 2'd0, 3'd0, 8'h22}, // R4 R5 mixed
        {32'h0001_2345, 1'b0, 2'd0, 3'd0, 8'h10}, // R5 full id
        {32'h0000_0105, 1'b0, 2'd0, 3'd0, 8'h02}, // R4 high bits ignored
        {32'h0000_00FF, 1'b0, 2'd0, 3'd0, 8'h8F}, // R4 legacy broadcast
        {32'hFFFF_FFFF, 1'b0, 2'd0, 3'd0, 8'hBF}, // R5 R10 all
        {32'h0000_0001, 1'b1, 2'd0, 3'd0, 8'h01}, // R7 flat
        {32'h0000_0006, 1'b1, 2'd0, 3'd0, 8'h02}, // R7 flat
        {32'h0000_0021, 1'b1, 2'd0, 3'd0, 8'h05}, // R8 cluster 2
        {32'h0000_0031, 1'b1, 2'd0, 3'd0, 8'h01}, // R8 cluster miss on member
        {32'h0000_00F3, 1'b1, 2'd0, 3'd0, 8'h0F}, // R8 wildcard cluster
        {32'h0001_0001, 1'b1, 2'd0, 3'd0, 8'h11}, // R6 ext cluster 1
        {32'h0001_0004, 1'b1, 2'd0, 3'd0, 8'h82}, // R6 ext member 4
        {32'h0002_0001, 1'b1, 2'd0, 3'd0, 8'h21}, // R6 ext cluster 2
        {32'hFFFF_FFFF, 1'b1, 2'd0, 3'd0, 8'hBF}, // R9 logical all-ones
        {32'h0000_0000, 1'b1, 2'd0, 3'd0, 8'h00}, // R11 empty
        {32'h0000_0000, 1'b0, 2'd1, 3'd3, 8'h08}, // R3 self
        {32'h0000_0000, 1'b0, 2'd1, 3'd6, 8'h00}, // R3 R10 self absent
        {32'h0000_0003, 1'b1, 2'd2, 3'd2, 8'hBF}, // R3 all
        {32'h0000_0000, 1'b0, 2'd3, 3'd7, 8'h3F}  // R3 others
    };

    task automatic set_agent(input int i, input bit p, input bit e, input bit c,
                             input logic [31:0] pid, input logic [31:0] lid);
        cfg_present[i] = p;
        cfg_ext[i]     = e;
        cfg_cluster[i] = c;
        cfg_phys_id[i*32 +: 32] = pid;
        cfg_log_id[i*32 +: 32]  = lid;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one request and check the registered result one cycle later.
    task automatic run(input logic [31:0] d, input bit lg, input logic [1:0] sh,
                       input logic [IW-1:0] snd, input logic [N-1:0] exp, input string req);
        bit found_e = 1'b0;
        logic [IW-1:0] idx_e = '0;
        @(negedge clk);
        req_dest = d; req_logical = lg; req_shorthand = sh; req_sender = snd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = N - 1; i >= 0; i--) if (exp[i]) begin found_e = 1'b1; idx_e = IW'(i); end
        check({req, " R2 valid"}, 32'(out_valid), 32'd1);
        check(req, 32'(out_mask), 32'(exp));
        check("R11 found", 32'(out_pick_found), 32'(found_e));
        if (found_e) check("R11 idx", 32'(out_pick_idx), 32'(idx_e));
    endtask

    initial begin
        set_agent(0, 1, 0, 0, 32'h0000_0003, 32'h0000_0001);
        set_agent(1, 1, 0, 0, 32'h0000_0105, 32'h0000_0006);
        set_agent(2, 1, 0, 1, 32'h0000_0010, 32'h0000_0021);
        set_agent(3, 1, 0, 1, 32'h0000_0011, 32'h0000_0032);
        set_agent(4, 1, 1, 0, 32'h0001_2345, 32'h0001_0003);
        set_agent(5, 1, 1, 0, 32'h0000_0005, 32'h0002_0001);
        set_agent(6, 0, 0, 0, 32'h0000_0003, 32'h0000_00FF);
        set_agent(7, 1, 1, 0, 32'h0000_00FF, 32'h0001_0004);
        repeat (3) @(negedge clk);
        check("R1 valid", 32'(out_valid), 32'd0);
        check("R1 mask", 32'(out_mask), 32'd0);
        check("R1 found", 32'(out_pick_found), 32'd0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++)
            run(VEC[v][45:14], VEC[v][13], VEC[v][12:11], VEC[v][10:8], VEC[v][7:0], "R3-R10 vector");

        // R2: idle cycle keeps the last mask and drops the strobe.
        run(32'h0001_0004, 1'b1, 2'd0, 3'd0, 8'h82, "R6 before hold");
        req_dest = 32'hFFFF_FFFF;
        @(negedge clk);
        check("R2 idle valid", 32'(out_valid), 32'd0);
        check("R2 hold mask", 32'(out_mask), 32'h82);
        check("R2 hold idx", 32'(out_pick_idx), 32'd1);

        // R10: remove agent 0, its physical ID no longer hits.
        cfg_present[0] = 1'b0;
        run(32'h0000_0003, 1'b0, 2'd0, 3'd0, 8'h00, "R10 removed agent");
        run(32'h0000_0000, 1'b0, 2'd3, 3'd1, 8'hBC, "R3 R10 others");
        cfg_present[0] = 1'b1;
        run(32'h0000_0000, 1'b0, 2'd1, 3'd0, 8'h01, "R3 self idx 0");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule